// File: doc/BRIEF.md
# Marginal Gain Cache Share Selector

This block decides how many cache colors each of four cores should keep powered. Software loads four candidate allocations per core, each with the miss count measured at that size, together with two weights. These weights price one miss and one powered color. After a start pulse the block first reduces every core to two candidates. It keeps the smallest allocation, plus the one reached by the step whose miss reduction per added color is largest. It then walks all sixteen ways of picking one of the two survivors per core, at one combination per clock. It keeps the cheapest combination whose colors fit the cache.

The result is one color count per core, held until the next search completes. A one-cycle done pulse marks the moment the counts become valid. The block sits beside the cache controller's remapping logic. Firmware loads it, starts it, and copies the counts into the color mapping tables when done rises.

Top module: `msel_top`

## Requirements
- R1: While reset is held and after it is released, done is 0 and every chosen color count is 0.
- R2: Each candidate's allocation is given as a 3-bit exponent e, meaning 2^e colors. Candidates are listed by index 0 to 3 in increasing size. Each miss count is a 16-bit unsigned value.
- R3: For each step j (0 to 2) between candidate j and j+1, the gain is floor(max(missj - missj+1, 0) * 256 / (colorsj+1 - colorsj)). The gain is 0 when the color difference is 0.
- R4: Per core, the kept low candidate is index 0. The kept high candidate is index j+1 for the step j with the largest gain, and the lowest j wins a tie.
- R5: Combination k (0 to 15) gives core c its high candidate when bit c of k is 1, and its low candidate otherwise.
- R6: The cost of a combination is missWeight * (sum of chosen misses) + colorWeight * (sum of chosen colors). A combination fits only if its color sum is at most 128, and a sum of exactly 128 fits.
- R7: The result is the fitting combination with the smallest cost. When costs are equal, the lower combination index wins.
- R8: If no combination fits, combination 0 (every core on its low candidate) is reported.
- R9: done is high for exactly one cycle, 16 cycles after the edge at which start is accepted. chosenColors takes the new counts on that same edge and then holds them until the next search completes.
- R10: start is ignored while a search runs. Inputs are captured at the accepting edge, and later changes to them do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; accepted only when idle |
| candExp | input | 4x4x3 | Color exponent per core and candidate |
| candMiss | input | 4x4x16 | Miss count per core and candidate |
| missWeight | input | 8 | Cost weight of one miss |
| colorWeight | input | 8 | Cost weight of one powered color |
| done | output | 1 | One-cycle pulse when the result is valid |
| chosenColors | output | 4x8 | Chosen color count per core |

## Verification
Both results land on the same edge, the sixteenth after the edge that accepts start: done rises and chosenColors loads. The bench drives and samples on falling edges. It counts sixteen falling edges after the one that drops start. It requires done to stay low on each earlier falling edge, high on the sixteenth, and low again on the next. The counts are compared on the sixteenth falling edge and again one cycle later to confirm they are held. In the disturbed run, start and the inputs are changed in the third cycle of a search, and the result must still match the values captured at the accepting edge.

// File: rtl/msel_pkg.sv
package msel_pkg;
  typedef struct packed {
    logic load;
    logic eval;
    logic first;
    logic last;
  } msStrobe_t;
endpackage

// File: rtl/msel_prune.sv
module msel_prune #(
  parameter int NCAND  = 4,
  parameter int EXP_W  = 3,
  parameter int MISS_W = 16,
  parameter int COL_W  = 8,
  parameter int FRAC   = 8
) (
  input  logic [NCAND-1:0][EXP_W-1:0]  exps,
  input  logic [NCAND-1:0][MISS_W-1:0] misses,
  output logic [EXP_W-1:0]             loExp,
  output logic [EXP_W-1:0]             hiExp,
  output logic [MISS_W-1:0]            loMiss,
  output logic [MISS_W-1:0]            hiMiss
);
  localparam int NUM_W = MISS_W + FRAC;
  localparam int SEL_W = $clog2(NCAND);

  logic [NUM_W-1:0] gain [NCAND-1];
  logic [SEL_W-1:0] bestStep;
  logic [SEL_W-1:0] hiSel;

  always_comb begin
    for (int j = 0; j < NCAND - 1; j++) begin
      logic [COL_W-1:0]  colLo, colHi, den;
      logic [MISS_W-1:0] drop;
      colLo = COL_W'(1) << exps[j];
      colHi = COL_W'(1) << exps[j+1];
      den   = (colHi > colLo) ? colHi - colLo : '0;
      drop  = (misses[j] > misses[j+1]) ? misses[j] - misses[j+1] : '0;
      gain[j] = (den == '0) ? '0 : (NUM_W'(drop) << FRAC) / NUM_W'(den);
    end
  end

  always_comb begin
    bestStep = '0;
    for (int j = 1; j < NCAND - 1; j++)
      if (gain[j] > gain[bestStep]) bestStep = SEL_W'(j);
    hiSel = bestStep + SEL_W'(1);
  end

  assign loExp  = exps[0];
  assign loMiss = misses[0];
  assign hiExp  = exps[hiSel];
  assign hiMiss = misses[hiSel];
endmodule

// File: rtl/msel_ctrl.sv
module msel_ctrl
  import msel_pkg::*;
#(
  parameter int NCORE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output msStrobe_t        stb,
  output logic [NCORE-1:0] comboIdx,
  output logic             done
);
  localparam int NCOMBO = 1 << NCORE;

  logic             busy;
  logic [NCORE-1:0] cnt;

  always_comb begin
    stb.load  = start && !busy;
    stb.eval  = busy;
    stb.first = busy && (cnt == '0);
    stb.last  = busy && (cnt == NCORE'(NCOMBO - 1));
  end

  assign comboIdx = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= stb.last;
      if (stb.load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + NCORE'(1);
        if (stb.last) busy <= 1'b0;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  last_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> done);
  // R10
  idle_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> cnt == '0);
endmodule

// File: rtl/msel_dpath.sv
module msel_dpath
  import msel_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int NCAND  = 4,
  parameter int EXP_W  = 3,
  parameter int MISS_W = 16,
  parameter int COL_W  = 8,
  parameter int WGT_W  = 8,
  parameter int FRAC   = 8,
  parameter int BUDGET = 128
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  msStrobe_t                        stb,
  input  logic [NCORE-1:0]                 comboIdx,
  input  logic [NCORE-1:0][NCAND-1:0][EXP_W-1:0]  candExp,
  input  logic [NCORE-1:0][NCAND-1:0][MISS_W-1:0] candMiss,
  input  logic [WGT_W-1:0]                 missWeight,
  input  logic [WGT_W-1:0]                 colorWeight,
  output logic [NCORE-1:0][COL_W-1:0]      chosenColors
);
  localparam int SUMM_W = MISS_W + $clog2(NCORE);
  localparam int SUMC_W = COL_W + $clog2(NCORE);
  localparam int COST_W = SUMM_W + WGT_W + 1;

  logic [NCORE-1:0][EXP_W-1:0]  pLoExp, pHiExp, loExp, hiExp;
  logic [NCORE-1:0][MISS_W-1:0] pLoMiss, pHiMiss, loMiss, hiMiss;
  logic [WGT_W-1:0]             wMiss, wColor;

  for (genvar c = 0; c < NCORE; c++) begin : g_prune
    msel_prune #(
      .NCAND(NCAND), .EXP_W(EXP_W), .MISS_W(MISS_W), .COL_W(COL_W), .FRAC(FRAC)
    ) u_prune (
      .exps(candExp[c]), .misses(candMiss[c]),
      .loExp(pLoExp[c]), .hiExp(pHiExp[c]),
      .loMiss(pLoMiss[c]), .hiMiss(pHiMiss[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loExp  <= '0;
      hiExp  <= '0;
      loMiss <= '0;
      hiMiss <= '0;
      wMiss  <= '0;
      wColor <= '0;
    end else if (stb.load) begin
      loExp  <= pLoExp;
      hiExp  <= pHiExp;
      loMiss <= pLoMiss;
      hiMiss <= pHiMiss;
      wMiss  <= missWeight;
      wColor <= colorWeight;
    end
  end

  logic [SUMM_W-1:0] sumMiss;
  logic [SUMC_W-1:0] sumCol;
  logic [COST_W-1:0] cost;
  logic              fits;

  always_comb begin
    sumMiss = '0;
    sumCol  = '0;
    for (int c = 0; c < NCORE; c++) begin
      sumMiss = sumMiss + SUMM_W'(comboIdx[c] ? hiMiss[c] : loMiss[c]);
      sumCol  = sumCol + SUMC_W'(COL_W'(1) << (comboIdx[c] ? hiExp[c] : loExp[c]));
    end
    cost = COST_W'(wMiss) * COST_W'(sumMiss) + COST_W'(wColor) * COST_W'(sumCol);
    fits = (sumCol <= SUMC_W'(BUDGET));
  end

  logic [COST_W-1:0] bestCost;
  logic [NCORE-1:0]  bestIdx, nextIdx;
  logic              bestFit, nextFit, take;
  logic              resFit;

  always_comb begin
    take    = stb.first || (fits && (!bestFit || cost < bestCost));
    nextIdx = take ? comboIdx : bestIdx;
    nextFit = take ? fits : bestFit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestCost     <= '0;
      bestIdx      <= '0;
      bestFit      <= 1'b0;
      chosenColors <= '0;
      resFit       <= 1'b0;
    end else if (stb.eval) begin
      if (take) begin
        bestCost <= cost;
        bestIdx  <= comboIdx;
        bestFit  <= fits;
      end
      if (stb.last) begin
        resFit <= nextFit;
        for (int c = 0; c < NCORE; c++)
          chosenColors[c] <= COL_W'(1) << (nextIdx[c] ? hiExp[c] : loExp[c]);
      end
    end
  end

  logic [SUMC_W-1:0] chkSum;
  always_comb begin
    chkSum = '0;
    for (int c = 0; c < NCORE; c++) chkSum = chkSum + SUMC_W'(chosenColors[c]);
  end

  // R6
  result_fits_chk: assert property (@(posedge clk) disable iff (!rstN)
    resFit |-> chkSum <= SUMC_W'(BUDGET));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.last |=> $stable(chosenColors));
endmodule

// File: rtl/msel_top.sv
module msel_top #(
  parameter int NCORE  = 4,
  parameter int NCAND  = 4,
  parameter int EXP_W  = 3,
  parameter int MISS_W = 16,
  parameter int COL_W  = 8,
  parameter int WGT_W  = 8,
  parameter int FRAC   = 8,
  parameter int BUDGET = 128
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    start,
  input  logic [NCORE-1:0][NCAND-1:0][EXP_W-1:0]  candExp,
  input  logic [NCORE-1:0][NCAND-1:0][MISS_W-1:0] candMiss,
  input  logic [WGT_W-1:0]                        missWeight,
  input  logic [WGT_W-1:0]                        colorWeight,
  output logic                                    done,
  output logic [NCORE-1:0][COL_W-1:0]             chosenColors
);
  msel_pkg::msStrobe_t stb;
  logic [NCORE-1:0]    comboIdx;

  msel_ctrl #(.NCORE(NCORE)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .stb(stb), .comboIdx(comboIdx), .done(done)
  );

  msel_dpath #(
    .NCORE(NCORE), .NCAND(NCAND), .EXP_W(EXP_W), .MISS_W(MISS_W),
    .COL_W(COL_W), .WGT_W(WGT_W), .FRAC(FRAC), .BUDGET(BUDGET)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .comboIdx(comboIdx),
    .candExp(candExp), .candMiss(candMiss),
    .missWeight(missWeight), .colorWeight(colorWeight),
    .chosenColors(chosenColors)
  );
endmodule

// File: tb/tb_msel_top.sv
module tb_msel_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0][3:0][2:0]  candExp = '0;
  logic [3:0][3:0][15:0] candMiss = '0;
  logic [7:0] missWeight = '0;
  logic [7:0] colorWeight = '0;
  logic done;
  logic [3:0][7:0] chosenColors;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  msel_top dut (
    .clk(clk), .rstN(rstN), .start(start), .candExp(candExp), .candMiss(candMiss),
    .missWeight(missWeight), .colorWeight(colorWeight),
    .done(done), .chosenColors(chosenColors)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(bit ok, string req, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // reference: R3..R8 computed arithmetically
  function automatic logic [3:0][7:0] model();
    logic [3:0][7:0] res;
    longint loC[4], hiC[4], loM[4], hiM[4];
    longint bestCost;
    int bestIdx;
    for (int c = 0; c < 4; c++) begin
      longint g[3];
      int bj;
      for (int j = 0; j < 3; j++) begin
        longint drop, den;
        drop = longint'(candMiss[c][j]) - longint'(candMiss[c][j+1]);
        if (drop < 0) drop = 0;
        den = (longint'(1) << candExp[c][j+1]) - (longint'(1) << candExp[c][j]);
        g[j] = (den <= 0) ? 0 : (drop * 256) / den;
      end
      bj = 0;
      for (int j = 1; j < 3; j++) if (g[j] > g[bj]) bj = j;
      loC[c] = longint'(1) << candExp[c][0];
      loM[c] = candMiss[c][0];
      hiC[c] = longint'(1) << candExp[c][bj+1];
      hiM[c] = candMiss[c][bj+1];
    end
    bestIdx = -1;
    bestCost = 0;
    for (int k = 0; k < 16; k++) begin
      longint sm, sc, cost;
      sm = 0; sc = 0;
      for (int c = 0; c < 4; c++) begin
        sm += k[c] ? hiM[c] : loM[c];
        sc += k[c] ? hiC[c] : loC[c];
      end
      cost = longint'(missWeight) * sm + longint'(colorWeight) * sc;
      if (sc <= 128 && (bestIdx < 0 || cost < bestCost)) begin
        bestIdx = k;
        bestCost = cost;
      end
    end
    if (bestIdx < 0) bestIdx = 0;
    for (int c = 0; c < 4; c++)
      res[c] = 8'(bestIdx[c] ? hiC[c] : loC[c]);
    return res;
  endfunction

  task automatic fillRandom();
    for (int c = 0; c < 4; c++) begin
      int e, slack;
      logic [31:0] r;
      r = rnd();
      e = int'(r % 5);
      slack = 4 - e;
      candExp[c][0] = 3'(e);
      for (int j = 1; j < 4; j++) begin
        e = e + 1;
        if (slack > 0 && r[8+j]) begin
          e = e + 1;
          slack--;
        end
        candExp[c][j] = 3'(e);
      end
      for (int j = 0; j < 4; j++) candMiss[c][j] = rnd() % 16'hffff;
      if (r[20]) begin
        for (int j = 1; j < 4; j++)
          if (candMiss[c][j] > candMiss[c][j-1]) candMiss[c][j] = candMiss[c][j-1] - 16'(rnd() % 50);
      end
    end
    missWeight = 8'(rnd());
    colorWeight = 8'(rnd());
  endtask

  // one search; start driven at a falling edge, results sampled at falling edges
  task automatic runCase(string req, bit disturb);
    logic [3:0][7:0] expv;
    bit early;
    expv = model();
    early = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (done) early = 1'b1;
    for (int k = 2; k <= 16; k++) begin
      @(negedge clk);
      if (done) early = 1'b1;
      if (disturb && k == 3) begin
        fillRandom();
        start = 1'b1;
      end
      if (disturb && k == 4) start = 1'b0;
    end
    check(!early, "R9 done early", early, 0);
    @(negedge clk);
    check(done == 1'b1, "R9 done due", done, 1);
    check(chosenColors == expv, req, chosenColors, expv);
    @(negedge clk);
    check(done == 1'b0, "R9 done pulse", done, 0);
    check(chosenColors == expv, "R9 hold", chosenColors, expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && chosenColors == '0, "R1 in reset", {done, chosenColors}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && chosenColors == '0, "R1 after reset", {done, chosenColors}, 0);

    // R3 R4 R7: core0 biggest gain at step 8->16 (199200), other cores flat
    candExp[0] = {3'd5, 3'd4, 3'd3, 3'd0};
    candMiss[0] = {16'd14000, 16'd14561, 16'd20786, 16'd21000};
    for (int c = 1; c < 4; c++) begin
      candExp[c] = {3'd3, 3'd2, 3'd1, 3'd0};
      candMiss[c] = {16'd100, 16'd100, 16'd100, 16'd100};
    end
    missWeight = 8'd1;
    colorWeight = 8'd0;
    runCase("R4 R7 gain pick and tie", 1'b0);
    check(chosenColors == {8'd1, 8'd1, 8'd1, 8'd16}, "R3 R4 directed", chosenColors,
          {8'd1, 8'd1, 8'd1, 8'd16});

    // R8: nothing fits, all low (64 each)
    for (int c = 0; c < 4; c++) begin
      candExp[c] = {3'd7, 3'd7, 3'd7, 3'd6};
      candMiss[c] = {16'd10, 16'd10, 16'd10, 16'd900};
    end
    runCase("R8 no fit", 1'b0);
    check(chosenColors == {4{8'd64}}, "R8 directed", chosenColors, {4{8'd64}});

    // R6 boundary: all low sum exactly 128 fits
    for (int c = 0; c < 4; c++) begin
      candExp[c] = {3'd7, 3'd7, 3'd6, 3'd5};
      candMiss[c] = {16'd0, 16'd0, 16'd0, 16'd1000};
    end
    runCase("R6 budget edge", 1'b0);
    check(chosenColors == {4{8'd32}}, "R6 directed", chosenColors, {4{8'd32}});

    // R10: restart and input change mid-search ignored
    fillRandom();
    runCase("R10 disturbed", 1'b1);

    // R2 R5 R6 R7 sweep
    for (int n = 0; n < 300; n++) begin
      fillRandom();
      runCase("R5 R6 R7 sweep", 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule